// File: doc/BRIEF.md
# Pin Control Bank with Edge and Level Event Detection

This block keeps one 32-bit control word for each pin of a small group of general-purpose pins. Each word carries pad settings (pull direction and enable, slow slew, input filter, open drain, high drive), a three-bit function select, a one-way lock, a four-bit event mode and an event flag. The pad settings and function select are held and sent out to the pad ring and the function multiplexer. The block does not act on them.

Each pin input passes through a synchroniser. A detector compares the synchronised sample with the previous one and looks for the edge or level that the mode field asks for. A hit sets the pin's flag. A flag raised in an interrupt mode feeds the shared interrupt line. A flag raised in a DMA mode drives that pin's DMA request, and a done pulse from the DMA engine clears it. Software selects a word with `reg_sel`, reads it back combinationally, and writes it in one clock cycle.

Top module: `pinctl_bank`

## Requirements
- R1: After reset every word reads 0, and `irq`, `dma_req`, `pad_attr` and `func_sel` are all 0.
- R2: A write stores bits 0,1,2,4,5,6 as the pad settings, bits 10:8 as the function select, bits 19:16 as the mode and bit 15 as the lock. Unused bits read 0. `pad_attr` for a pin is {bit6,bit5,bit4,bit2,bit1,bit0} and `func_sel` is bits 10:8.
- R3: Once bit 15 is 1, writes no longer change bits 15:0 and the lock cannot be cleared by software. The mode field and the flag stay writable. Only reset clears the lock.
- R4: Modes 9, 10 and 11 set the flag on a rising, falling or either edge of the pin, and the flag raises `irq`.
- R5: Mode 8 sets the flag while the pin is low and mode 12 sets it while the pin is high. The flag raises `irq`.
- R6: Writing 1 to bit 24 clears the flag. Writing 0 to bit 24 leaves it unchanged.
- R7: In a level mode, a clear while the level is still active drops the flag for exactly one cycle, and the flag is then set again.
- R8: Modes 1, 2 and 3 set the flag on a rising, falling or either edge. In these modes `dma_req` for that pin follows the flag and `irq` is not raised.
- R9: In a DMA mode, a pulse on the pin's `dma_done` clears its flag. In an interrupt mode, `dma_done` has no effect.
- R10: Mode 0 and the unlisted codes 4 to 7 and 13 to 15 never set the flag.
- R11: When a detection and a write-1 clear fall on the same clock edge, the flag stays set.
- R12: `irq` is the OR over all pins of the flags held in interrupt modes. A write to one pin's word leaves the other words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_sel | input | SEL_W | Word (pin) select for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| pin_in | input | NUM_PINS | Raw pin inputs, asynchronous to clk |
| dma_done | input | NUM_PINS | Per-pin DMA transfer complete pulse |
| irq | output | 1 | Combined interrupt line |
| dma_req | output | NUM_PINS | Per-pin DMA request |
| pad_attr | output | NUM_PINS*6 | Stored pad settings, 6 bits per pin |
| func_sel | output | NUM_PINS*3 | Stored function select, 3 bits per pin |

## Verification
A pin change is seen by the flag on the third rising edge after it, because it passes two synchroniser flops and then the flag register. The bench therefore waits four clocks after each pin change before it samples. Register writes and clears take effect on the edge that captures them. Readback is combinational, so the bench checks these one half-cycle after that edge. In a level mode the flag comes back one edge after a clear, so that check is taken in the half-cycle right after the clear and again one clock later. The same-edge case is arranged by issuing the clear exactly two clocks after the pin toggle. All sampling happens on falling edges.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

  localparam int WORD_W   = 32;
  localparam int MODE_W   = 4;
  localparam int FUNC_W   = 3;
  localparam int PAD_W    = 6;
  localparam int FLAG_BIT = 24;
  localparam int LOCK_BIT = 15;
  localparam int MODE_LSB = 16;
  localparam int FUNC_LSB = 8;

  typedef logic [MODE_W-1:0] mode_t;

  // DMA request modes: edge sensing only
  function automatic logic is_dma_mode(mode_t m);
    return (m == 4'd1) || (m == 4'd2) || (m == 4'd3);
  endfunction

  // interrupt modes: levels 8/12, edges 9..11
  function automatic logic is_irq_mode(mode_t m);
    return (m >= 4'd8) && (m <= 4'd12);
  endfunction

  function automatic logic edge_match(mode_t m, logic prev, logic cur);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = prev & ~cur;
    case (m)
      4'd1, 4'd9:  return rise;
      4'd2, 4'd10: return fall;
      4'd3, 4'd11: return rise | fall;
      default:     return 1'b0;
    endcase
  endfunction

  function automatic logic level_match(mode_t m, logic cur);
    case (m)
      4'd8:    return ~cur;
      4'd12:   return cur;
      default: return 1'b0;
    endcase
  endfunction

  // pad settings packed as {drive, odrain, filter, slew, pull_en, pull_up}
  function automatic logic [PAD_W-1:0] pad_from_word(logic [WORD_W-1:0] w);
    return {w[6], w[5], w[4], w[2], w[1], w[0]};
  endfunction

  function automatic logic [WORD_W-1:0] compose_word(logic flag, mode_t mode, logic lock,
                                                     logic [FUNC_W-1:0] func,
                                                     logic [PAD_W-1:0] pad);
    logic [WORD_W-1:0] w;
    w = '0;
    w[FLAG_BIT] = flag;
    w[MODE_LSB +: MODE_W] = mode;
    w[LOCK_BIT] = lock;
    w[FUNC_LSB +: FUNC_W] = func;
    w[6:4] = pad[5:3];
    w[2:0] = pad[2:0];
    return w;
  endfunction

endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pinctl_detect.sv
module pinctl_detect
  import pinctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sample,
  input  mode_t mode,
  output logic  edge_hit,
  output logic  level_hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sample;
  end

  assign edge_hit  = edge_match(mode, prev_q, sample);
  assign level_hit = level_match(mode, sample);
endmodule

// File: rtl/pinctl_pin.sv
module pinctl_pin
  import pinctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_raw,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              dma_done,
  output logic [WORD_W-1:0] rd_word,
  output logic [PAD_W-1:0]  pad_attr,
  output logic [FUNC_W-1:0] func_sel,
  output logic              flag,
  output logic              lock,
  output logic              set_ev,
  output logic              clr_ev,
  output logic              irq_src,
  output logic              dma_req,
  output logic              dma_mode
);
  logic [PAD_W-1:0]  pad_q;
  logic [FUNC_W-1:0] func_q;
  logic              lock_q;
  mode_t             mode_q;
  logic              flag_q;
  logic              sync_s;
  logic              edge_hit;
  logic              level_hit;
  logic              clr_by_sw;
  logic              clr_by_dma;

  pinctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(sync_s)
  );

  pinctl_detect u_det (
    .clk(clk), .rst_n(rst_n), .sample(sync_s), .mode(mode_q),
    .edge_hit(edge_hit), .level_hit(level_hit)
  );

  // configuration: low half frozen by lock, mode always writable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q  <= '0;
      func_q <= '0;
      lock_q <= 1'b0;
      mode_q <= '0;
    end else if (wr_en) begin
      mode_q <= wdata[MODE_LSB +: MODE_W];
      if (!lock_q) begin
        pad_q  <= pad_from_word(wdata);
        func_q <= wdata[FUNC_LSB +: FUNC_W];
        lock_q <= wdata[LOCK_BIT];
      end
    end
  end

  assign dma_mode   = is_dma_mode(mode_q);
  assign clr_by_sw  = wr_en & wdata[FLAG_BIT];
  assign clr_by_dma = dma_done & dma_mode;
  assign clr_ev     = clr_by_sw | clr_by_dma;
  // an edge beats a clear; a level returns one cycle after a clear
  assign set_ev     = edge_hit | (level_hit & ~clr_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= set_ev | (flag_q & ~clr_ev);
  end

  assign flag     = flag_q;
  assign lock     = lock_q;
  assign pad_attr = pad_q;
  assign func_sel = func_q;
  assign irq_src  = flag_q & is_irq_mode(mode_q);
  assign dma_req  = flag_q & dma_mode;
  assign rd_word  = compose_word(flag_q, mode_q, lock_q, func_q, pad_q);
endmodule

// File: rtl/pinctl_bank.sv
module pinctl_bank
  import pinctl_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [SEL_W-1:0]          reg_sel,
  input  logic [WORD_W-1:0]         reg_wdata,
  output logic [WORD_W-1:0]         reg_rdata,
  input  logic [NUM_PINS-1:0]       pin_in,
  input  logic [NUM_PINS-1:0]       dma_done,
  output logic                      irq,
  output logic [NUM_PINS-1:0]       dma_req,
  output logic [NUM_PINS*PAD_W-1:0] pad_attr,
  output logic [NUM_PINS*FUNC_W-1:0] func_sel
);
  logic [WORD_W-1:0]   words [NUM_PINS];
  logic [NUM_PINS-1:0] flag_vec;
  logic [NUM_PINS-1:0] lock_vec;
  logic [NUM_PINS-1:0] set_vec;
  logic [NUM_PINS-1:0] clr_vec;
  logic [NUM_PINS-1:0] irq_src_vec;
  logic [NUM_PINS-1:0] dma_mode_vec;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic wr_hit;
    assign wr_hit = reg_wr && (reg_sel == SEL_W'(i));

    pinctl_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_raw  (pin_in[i]),
      .wr_en    (wr_hit),
      .wdata    (reg_wdata),
      .dma_done (dma_done[i]),
      .rd_word  (words[i]),
      .pad_attr (pad_attr[i*PAD_W +: PAD_W]),
      .func_sel (func_sel[i*FUNC_W +: FUNC_W]),
      .flag     (flag_vec[i]),
      .lock     (lock_vec[i]),
      .set_ev   (set_vec[i]),
      .clr_ev   (clr_vec[i]),
      .irq_src  (irq_src_vec[i]),
      .dma_req  (dma_req[i]),
      .dma_mode (dma_mode_vec[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NUM_PINS; k++)
      if (reg_sel == SEL_W'(k)) reg_rdata = words[k];
  end

  assign irq = |irq_src_vec;
endmodule

// File: rtl/pinctl_bank_chk.sv
module pinctl_bank_chk #(
  parameter int NUM_PINS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] flag_vec,
  input logic [NUM_PINS-1:0] lock_vec,
  input logic [NUM_PINS-1:0] set_vec,
  input logic [NUM_PINS-1:0] clr_vec,
  input logic [NUM_PINS-1:0] dma_mode_vec,
  input logic [NUM_PINS-1:0] dma_done,
  input logic                irq
);
  // R1: held reset leaves no flag and no lock
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (flag_vec == '0) && (lock_vec == '0));

  // R12: the shared line needs some flag behind it
  p_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_vec != '0));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    // R3: lock only leaves through reset
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lock_vec[i] |=> lock_vec[i]);

    // R4: a flag never appears without a detection
    p_flag_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_vec[i]) |-> $past(set_vec[i]));

    // R6: a clear with no competing detection empties the flag
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vec[i] && !set_vec[i] |=> !flag_vec[i]);

    // R11: a detection always lands, clear or not
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flag_vec[i]);

    // R9: DMA completion retires the request
    p_dma_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_mode_vec[i] && dma_done[i] && !set_vec[i] |=> !flag_vec[i]);
  end
endmodule

bind pinctl_bank pinctl_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flag_vec     (flag_vec),
  .lock_vec     (lock_vec),
  .set_vec      (set_vec),
  .clr_vec      (clr_vec),
  .dma_mode_vec (dma_mode_vec),
  .dma_done     (dma_done),
  .irq          (irq)
);

// File: tb/sim_pinctl_bank.sv
module sim_pinctl_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NVEC = 17;

  // vector: {mode[3:0], start level, end level, expected flag, unused}
  localparam logic [7:0] VEC [NVEC] = '{
    {4'd9,  1'b0, 1'b1, 1'b1, 1'b0},
    {4'd9,  1'b1, 1'b0, 1'b0, 1'b0},
    {4'd10, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'd10, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd11, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd11, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'd8,  1'b1, 1'b1, 1'b0, 1'b0},
    {4'd8,  1'b1, 1'b0, 1'b1, 1'b0},
    {4'd12, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd12, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd1,  1'b0, 1'b1, 1'b1, 1'b0},
    {4'd2,  1'b1, 1'b0, 1'b1, 1'b0},
    {4'd2,  1'b0, 1'b1, 1'b0, 1'b0},
    {4'd3,  1'b1, 1'b0, 1'b1, 1'b0},
    {4'd0,  1'b0, 1'b1, 1'b0, 1'b0},
    {4'd5,  1'b0, 1'b1, 1'b0, 1'b0},
    {4'd13, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] dma_done = '0;
  logic          irq;
  logic [NP-1:0] dma_req;
  logic [NP*6-1:0] pad_attr;
  logic [NP*3-1:0] func_sel;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  pinctl_bank #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .dma_done(dma_done), .irq(irq), .dma_req(dma_req),
    .pad_attr(pad_attr), .func_sel(func_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int p, logic [31:0] d);
    reg_sel = 2'(p);
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic rd(int p, output logic [31:0] d);
    reg_sel = 2'(p);
    #1 d = reg_rdata;
  endtask

  task automatic clear_all();
    for (int p = 0; p < NP; p++) wr(p, 32'h0100_0000);
  endtask

  task automatic dma_pulse(int p);
    dma_done[p] = 1'b1;
    @(negedge clk);
    dma_done[p] = 1'b0;
  endtask

  function automatic string req_of(logic [3:0] m);
    if (m >= 4'd1 && m <= 4'd3) return "R8";
    if (m == 4'd8 || m == 4'd12) return "R5";
    if (m >= 4'd9 && m <= 4'd11) return "R4";
    return "R10";
  endfunction

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1: reset values at every port and word
    for (int p = 0; p < NP; p++) begin
      rd(p, v);
      check("R1 word", v, 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 dma_req", {28'b0, dma_req}, 32'h0);
    check("R1 pad_attr", {8'b0, pad_attr}, 32'h0);
    check("R1 func_sel", {20'b0, func_sel}, 32'h0);

    // table of edge, level, DMA and unlisted modes
    for (int k = 0; k < NVEC; k++) begin
      int p;
      logic [3:0] m;
      logic s, e, x, exp_irq, exp_dma;
      p = k % NP;
      m = VEC[k][7:4];
      s = VEC[k][3];
      e = VEC[k][2];
      x = VEC[k][1];
      exp_irq = x & (m >= 4'd8) & (m <= 4'd12);
      exp_dma = x & (m >= 4'd1) & (m <= 4'd3);
      clear_all();
      pin_in[p] = s;
      tick(4);
      wr(p, {7'b0, 1'b1, 4'b0, m, 16'b0});
      pin_in[p] = e;
      tick(4);
      rd(p, v);
      check({req_of(m), " flag"}, {31'b0, v[24]}, {31'b0, x});
      check({req_of(m), " irq"}, {31'b0, irq}, {31'b0, exp_irq});
      check({req_of(m), " dma_req"}, {31'b0, dma_req[p]}, {31'b0, exp_dma});
    end

    // R2: field storage, reserved bits and exports
    clear_all();
    wr(1, 32'hFEF0_7F77);
    rd(1, v);
    check("R2 readback", v, 32'h0000_0777);
    check("R2 pad_attr", {26'b0, pad_attr[6 +: 6]}, 32'h3F);
    check("R2 func_sel", {29'b0, func_sel[3 +: 3]}, 32'h7);
    wr(1, 32'h0000_0215);
    rd(1, v);
    check("R2 readback2", v, 32'h0000_0215);
    check("R2 pad_attr2", {26'b0, pad_attr[6 +: 6]}, 32'h0D);
    check("R2 func_sel2", {29'b0, func_sel[3 +: 3]}, 32'h2);

    // R12: combined interrupt and per-pin isolation
    clear_all();
    pin_in[0] = 1'b0;
    pin_in[1] = 1'b1;
    tick(4);
    wr(0, 32'h0009_0000);
    wr(1, 32'h000A_0000);
    pin_in[0] = 1'b1;
    pin_in[1] = 1'b0;
    tick(4);
    check("R12 irq both", {31'b0, irq}, 32'h1);
    wr(0, 32'h0109_0000);
    check("R12 irq one left", {31'b0, irq}, 32'h1);
    rd(1, v);
    check("R12 other word", v, 32'h010A_0000);
    wr(1, 32'h010A_0000);
    check("R12 irq none", {31'b0, irq}, 32'h0);

    // R6: write-1 clears, write-0 keeps
    clear_all();
    pin_in[0] = 1'b0;
    tick(4);
    wr(0, 32'h0009_0000);
    pin_in[0] = 1'b1;
    tick(4);
    rd(0, v);
    check("R6 set", v, 32'h0109_0000);
    wr(0, 32'h0009_0000);
    rd(0, v);
    check("R6 zero keeps", v, 32'h0109_0000);
    wr(0, 32'h0109_0000);
    rd(0, v);
    check("R6 one clears", v, 32'h0009_0000);

    // R7: level still active after clear
    wr(0, 32'h000C_0000);
    tick(2);
    rd(0, v);
    check("R7 level set", v, 32'h010C_0000);
    wr(0, 32'h010C_0000);
    rd(0, v);
    check("R7 dropped", v, 32'h000C_0000);
    tick(1);
    rd(0, v);
    check("R7 back", v, 32'h010C_0000);

    // R11: detection and clear on the same edge
    clear_all();
    wr(0, 32'h000B_0000);
    rd(0, v);
    check("R11 idle", v, 32'h000B_0000);
    pin_in[0] = 1'b0;
    tick(2);
    wr(0, 32'h010B_0000);
    rd(0, v);
    check("R11 set wins", v, 32'h010B_0000);
    wr(0, 32'h010B_0000);
    rd(0, v);
    check("R11 later clear", v, 32'h000B_0000);

    // R9: DMA completion clears only in DMA modes
    clear_all();
    pin_in[3] = 1'b0;
    tick(4);
    wr(3, 32'h0001_0000);
    pin_in[3] = 1'b1;
    tick(4);
    check("R9 dma_req up", {28'b0, dma_req}, 32'h8);
    check("R9 no irq", {31'b0, irq}, 32'h0);
    dma_pulse(3);
    check("R9 dma_req down", {28'b0, dma_req}, 32'h0);
    rd(3, v);
    check("R9 flag cleared", v, 32'h0001_0000);
    wr(3, 32'h0009_0000);
    pin_in[3] = 1'b0;
    tick(4);
    pin_in[3] = 1'b1;
    tick(4);
    dma_pulse(3);
    rd(3, v);
    check("R9 irq mode ignores done", v, 32'h0109_0000);
    check("R9 irq kept", {31'b0, irq}, 32'h1);

    // R3: lock behaviour
    clear_all();
    pin_in[2] = 1'b0;
    tick(4);
    wr(2, 32'h0000_8123);
    rd(2, v);
    check("R3 locked write", v, 32'h0000_8123);
    check("R3 pad_attr", {26'b0, pad_attr[12 +: 6]}, 32'h13);
    wr(2, 32'h0000_0456);
    rd(2, v);
    check("R3 low half frozen", v, 32'h0000_8123);
    wr(2, 32'h0009_0456);
    rd(2, v);
    check("R3 mode writable", v, 32'h0009_8123);
    pin_in[2] = 1'b1;
    tick(4);
    rd(2, v);
    check("R3 flag sets", v, 32'h0109_8123);
    wr(2, 32'h0109_0000);
    rd(2, v);
    check("R3 flag clears", v, 32'h0009_8123);
    wr(2, 32'h0000_0000);
    rd(2, v);
    check("R3 lock stays", v, 32'h0000_8123);

    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    rd(2, v);
    check("R3 R1 reset unlocks", v, 32'h0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule